// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Select

This block chooses where each of the two ALU operands of the instruction in the execute stage comes from. It is used in a five-stage in-order integer pipeline. Each operand can take the value read from the register file. It can instead take the result that sits in the execute/memory pipeline register, or the result that sits in the memory/writeback pipeline register. This lets a dependent instruction run without waiting for its producer to write the register file.

The block is purely combinational and holds no state. For each operand it compares the source register number with the destination register numbers of the two older instructions. It forwards only from a stage that is really writing a register, and never for register zero. When both older stages write the register an operand needs, the younger producer wins, so back-to-back writes to one register deliver the newest value.

Top module: `operand_fwd_unit`

## Requirements
- R1: `fwd_sel_a` is 2'b10 (take the execute/memory result) when `exm_wr_en` is 1, `exm_dst` is nonzero and `exm_dst` equals `ex_src_a`.
- R2: `fwd_sel_b` is 2'b10 under the same condition tested against `ex_src_b`.
- R3: A select is 2'b01 (take the writeback result) when `mwb_wr_en` is 1, `mwb_dst` is nonzero and equals that operand's source, and the R1/R2 condition for that operand is false.
- R4: When the execute/memory and memory/writeback stages both qualify for the same operand, the select is 2'b10: the younger producer wins.
- R5: A stage whose write enable is 0 is never forwarded from, whatever its destination number.
- R6: A stage whose destination is register 0 is never forwarded from, even when its write enable is 1.
- R7: When neither stage qualifies, the select is 2'b00 (take the register-file value). The code 2'b11 never appears.
- R8: The two selects are independent. In one cycle, operand A and operand B may each pick a different source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex_src_a | input | 5 | First source register number of the execute-stage instruction |
| ex_src_b | input | 5 | Second source register number of the execute-stage instruction |
| exm_dst | input | 5 | Destination register number in the execute/memory pipeline register |
| exm_wr_en | input | 1 | Register-write flag in the execute/memory pipeline register |
| mwb_dst | input | 5 | Destination register number in the memory/writeback pipeline register |
| mwb_wr_en | input | 1 | Register-write flag in the memory/writeback pipeline register |
| fwd_sel_a | output | 2 | Operand A source: 00 register file, 01 writeback result, 10 execute/memory result |
| fwd_sel_b | output | 2 | Operand B source, same encoding as operand A |

## Verification
The hardest case to reach is a double hit. Both older stages write the same nonzero register, that register is an operand source, and the other operand still resolves on its own. The stimulus sweeps every field over the small set {0, 1, 2, 31}, with all four write-flag combinations. This lands on every mix of match and mismatch, including register zero against matching write flags and both sources naming the same producer. Directed vectors come first and set up the mixed-source cycle and the double-write case on purpose.

// File: rtl/fwd_pkg.sv
// Shared types for the operand forwarding select logic.
package fwd_pkg;

    // Operand source encoding driven onto the ALU input muxes.
    typedef enum logic [1:0] {
        SRC_REGFILE = 2'b00,
        SRC_WBACK   = 2'b01,
        SRC_EXMEM   = 2'b10
    } fwd_src_e;

endpackage

// File: rtl/fwd_hit_detect.sv
// fwd_hit_detect: reports whether one producer stage can supply one operand.
// Assumes register 0 is hard-wired and never a legal forwarding target.
module fwd_hit_detect #(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src_reg,
    input  logic [REG_AW-1:0] prod_dst,
    input  logic              prod_wr,
    output logic              hit
);

    // A hit needs a real write to a nonzero register that the operand names.
    always_comb begin
        hit = prod_wr && (prod_dst != '0) && (prod_dst == src_reg);
    end

endmodule

// File: rtl/fwd_sel_prio.sv
// fwd_sel_prio: turns the two per-stage hits into one mux select.
// Assumes the execute/memory stage holds the younger of the two producers.
module fwd_sel_prio
    import fwd_pkg::*;
(
    input  logic     exm_hit,
    input  logic     mwb_hit,
    output fwd_src_e sel
);

    // The younger producer wins; fall back to the register file otherwise.
    always_comb begin
        if (exm_hit)      sel = SRC_EXMEM;
        else if (mwb_hit) sel = SRC_WBACK;
        else              sel = SRC_REGFILE;
    end

endmodule

// File: rtl/operand_fwd_unit.sv
// operand_fwd_unit: forwarding selects for both ALU operands of the
// execute-stage instruction. Purely combinational, no state.
// Assumes the two selects are resolved independently of each other.
module operand_fwd_unit
    import fwd_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] ex_src_a,
    input  logic [REG_AW-1:0] ex_src_b,
    input  logic [REG_AW-1:0] exm_dst,
    input  logic              exm_wr_en,
    input  logic [REG_AW-1:0] mwb_dst,
    input  logic              mwb_wr_en,
    output logic [1:0]        fwd_sel_a,
    output logic [1:0]        fwd_sel_b
);

    localparam int NUM_OPS = 2;

    logic [REG_AW-1:0] src_vec [NUM_OPS];
    fwd_src_e          sel_vec [NUM_OPS];

    // Gather the operand sources into an indexable array.
    always_comb begin
        src_vec[0] = ex_src_a;
        src_vec[1] = ex_src_b;
    end

    for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
        logic exm_hit;
        logic mwb_hit;

        fwd_hit_detect #(.REG_AW(REG_AW)) u_exm_hit (
            .src_reg  (src_vec[i]),
            .prod_dst (exm_dst),
            .prod_wr  (exm_wr_en),
            .hit      (exm_hit)
        );

        fwd_hit_detect #(.REG_AW(REG_AW)) u_mwb_hit (
            .src_reg  (src_vec[i]),
            .prod_dst (mwb_dst),
            .prod_wr  (mwb_wr_en),
            .hit      (mwb_hit)
        );

        fwd_sel_prio u_prio (
            .exm_hit (exm_hit),
            .mwb_hit (mwb_hit),
            .sel     (sel_vec[i])
        );

        // Port-level checks of the resolved select for this operand.
        always_comb begin
            p_sel_legal_r7: assert (sel_vec[i] != fwd_src_e'(2'b11))
                else $error("illegal select code on operand %0d", i);
            p_younger_wins_r4: assert (!(exm_wr_en && exm_dst != '0 && exm_dst == src_vec[i])
                                       || sel_vec[i] == SRC_EXMEM)
                else $error("execute/memory producer not chosen on operand %0d", i);
            p_wb_qualified_r3: assert (sel_vec[i] != SRC_WBACK
                                       || (mwb_wr_en && mwb_dst != '0 && mwb_dst == src_vec[i]))
                else $error("writeback chosen without a qualifying producer on operand %0d", i);
            p_no_write_r5: assert (exm_wr_en || mwb_wr_en || sel_vec[i] == SRC_REGFILE)
                else $error("forwarded with no stage writing on operand %0d", i);
            p_zero_dst_r6: assert (exm_dst != '0 || mwb_dst != '0 || sel_vec[i] == SRC_REGFILE)
                else $error("forwarded a register-zero write on operand %0d", i);
        end
    end

    // Drive the output ports from the per-operand selects.
    always_comb begin
        fwd_sel_a = sel_vec[0];
        fwd_sel_b = sel_vec[1];
    end

endmodule

// File: tb/operand_fwd_unit_bench.sv
// Scoreboard bench: the driver applies a vector and queues the expected
// selects; the monitor compares them half a clock later.
module operand_fwd_unit_bench;

    localparam int AW = 5;

    typedef struct {
        logic [1:0] exp_a;
        logic [1:0] exp_b;
        string      tag;
    } exp_item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] ex_src_a = '0, ex_src_b = '0, exm_dst = '0, mwb_dst = '0;
    logic          exm_wr_en = 1'b0, mwb_wr_en = 1'b0;
    logic [1:0]    fwd_sel_a, fwd_sel_b;

    exp_item_t     sb_q[$];
    int            n_checks = 0;
    int            n_errors = 0;
    bit            drive_done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    operand_fwd_unit #(.REG_AW(AW)) u_operand_fwd_unit (
        .ex_src_a  (ex_src_a),
        .ex_src_b  (ex_src_b),
        .exm_dst   (exm_dst),
        .exm_wr_en (exm_wr_en),
        .mwb_dst   (mwb_dst),
        .mwb_wr_en (mwb_wr_en),
        .fwd_sel_a (fwd_sel_a),
        .fwd_sel_b (fwd_sel_b)
    );

    // Reference select for one operand, written from the requirements.
    function automatic logic [1:0] ref_sel(input logic [AW-1:0] src);
        logic ex_ok, wb_ok;
        ex_ok = exm_wr_en && (exm_dst != 0) && (exm_dst == src);   // R1 R2
        wb_ok = mwb_wr_en && (mwb_dst != 0) && (mwb_dst == src);   // R3 R5 R6
        if (ex_ok)      return 2'b10;                              // R4
        else if (wb_ok) return 2'b01;
        else            return 2'b00;                              // R7
    endfunction

    // Driver: apply one vector at a rising edge and queue its expectation.
    task automatic drive(input logic [AW-1:0] sa, input logic [AW-1:0] sb,
                         input logic [AW-1:0] ed, input logic ew,
                         input logic [AW-1:0] wd, input logic ww,
                         input string tag);
        exp_item_t it;
        @(posedge clk);
        ex_src_a = sa; ex_src_b = sb;
        exm_dst = ed; exm_wr_en = ew;
        mwb_dst = wd; mwb_wr_en = ww;
        it.exp_a = ref_sel(sa);
        it.exp_b = ref_sel(sb);
        it.tag   = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: compare outputs against queued expectations at falling edges.
    always @(negedge clk) begin
        if (sb_q.size() != 0) begin
            exp_item_t it;
            it = sb_q.pop_front();
            n_checks++;
            if (fwd_sel_a !== it.exp_a) begin
                n_errors++;
                $display("FAIL %s operand A: actual=%b expected=%b", it.tag, fwd_sel_a, it.exp_a);
            end
            n_checks++;
            if (fwd_sel_b !== it.exp_b) begin
                n_errors++;
                $display("FAIL %s operand B: actual=%b expected=%b", it.tag, fwd_sel_b, it.exp_b);
            end
            if (fwd_sel_a === 2'b11 || fwd_sel_b === 2'b11) begin
                n_errors++;
                $display("FAIL R7 illegal code: actual=%b/%b expected=not 11", fwd_sel_a, fwd_sel_b);
            end
        end
    end

    // Stimulus: reset state, directed corners, then a sweep.
    initial begin
        logic [AW-1:0] pick [4];
        pick[0] = 5'd0; pick[1] = 5'd1; pick[2] = 5'd2; pick[3] = 5'd31;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        drive(0, 0, 0, 0, 0, 0, "R7 idle after reset");
        drive(3, 4, 3, 1, 0, 0, "R1 exm to A");
        drive(4, 3, 3, 1, 0, 0, "R2 exm to B");
        drive(7, 9, 0, 0, 7, 1, "R3 wb to A");
        drive(6, 6, 6, 1, 6, 1, "R4 double write both operands");
        drive(8, 8, 8, 0, 8, 0, "R5 write flags low");
        drive(8, 8, 8, 0, 8, 1, "R5 exm flag low, wb forwards");
        drive(0, 0, 0, 1, 0, 1, "R6 register zero writes");
        drive(0, 5, 0, 1, 5, 1, "R6 zero on A, wb on B");
        drive(10, 11, 10, 1, 11, 1, "R8 A from exm, B from wb");
        drive(12, 13, 14, 1, 15, 1, "R7 no match");
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++)
                for (int e = 0; e < 4; e++)
                    for (int w = 0; w < 4; w++)
                        for (int f = 0; f < 4; f++)
                            drive(pick[a], pick[b], pick[e], f[0], pick[w], f[1], "R8 sweep");
        @(posedge clk);
        @(posedge clk);
        drive_done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        fork
            wait (drive_done && sb_q.size() == 0);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule